// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block produces the next control-store address of a microcoded engine on every cycle. The address can come from one of four places: an internal microprogram counter, an address register, the top of a small return-address stack, or a direct input. The direct input normally carries an instruction's start address from an opcode mapping table. The selected value is then ORed with a mask input, which gives cheap multi-way branches. An active-low zero input overrides everything and forces the address to zero.

The counter always reloads with the emitted address plus one. This lets a single source select, together with a separate stack enable and direction pair, express several operations: continuing, jumping, calling a subroutine, returning, and jumping to the stack top without popping it. The address register captures the microinstruction's immediate field on every clock. The address is 12 bits wide, and only its low 9 bits reach the 512-word control store.

Top module: `useq_addr_gen`

## Requirements
- R1: With `src_sel`=00, `y` equals the microprogram counter ORed with `or_mask`.
- R2: With `src_sel`=01, `y` equals the value `r_in` held at the previous rising edge (the address register loads every cycle), ORed with `or_mask`.
- R3: With `src_sel`=10, `y` equals the stack top ORed with `or_mask`; an empty stack reads as zero.
- R4: With `src_sel`=11, `y` equals `d_in` ORed with `or_mask` in the same cycle.
- R5: Every bit set in `or_mask` is set in `y` whenever `zero_n` is high.
- R6: While `zero_n` is low, `y` is zero whatever the other inputs are.
- R7: At every rising edge that is not in reset, the counter loads `y`+1, wrapping from 4095 to 0.
- R8: With `stk_en_n` low at an edge, `stk_push`=1 pushes the counter's value before that edge and `stk_push`=0 pops. With `stk_en_n` high, the stack is unchanged whatever `stk_push` is.
- R9: The stack holds 4 entries. A push when it is full overwrites the top entry, and a pop when it is empty changes nothing.
- R10: A rising edge with `rst_n` low clears the counter and the address register and empties the stack.
- R11: `cs_addr` always equals `y[8:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| src_sel | input | 2 | Address source: 00 counter, 01 address register, 10 stack top, 11 direct |
| stk_en_n | input | 1 | Active-low stack operation enable |
| stk_push | input | 1 | Stack direction: 1 push, 0 pop |
| r_in | input | 12 | Immediate field, captured into the address register each cycle |
| d_in | input | 12 | Direct address (instruction start address) |
| or_mask | input | 12 | Bits ORed into the selected address |
| zero_n | input | 1 | Active-low force of the output address to zero |
| y | output | 12 | Microaddress |
| cs_addr | output | 9 | Control-store address, low bits of `y` |

## Verification
Straight counter runs show that sequencing comes from the incrementer and not from a stale source, and a jump to 4095 shows that the counter wraps. Distinct values on `r_in`, `d_in` and a nonzero mask show that each source is routed to the output and that register and direct inputs differ by one cycle. Call and return sequences, five pushes into four entries, pops past empty, and a push with the enable high tell correct stack depth, overwrite and ignore behaviour apart from off-by-one pointer errors. A reset in the middle of a run shows that the stack is emptied and not merely hidden.

// File: rtl/useq_pkg.sv
// Package: shared encodings for the microprogram sequencer.
// Assumes a 2-bit source select drives the output multiplexer.
package useq_pkg;
    typedef enum logic [1:0] {
        SRC_UPC    = 2'b00,
        SRC_AREG   = 2'b01,
        SRC_STACK  = 2'b10,
        SRC_DIRECT = 2'b11
    } src_e;
endpackage

// File: rtl/useq_src_mux.sv
// Module: per-bit four-way source multiplexer with OR mask and zero force.
// Assumes all sources are already stable in the cycle; purely combinational.
module useq_src_mux #(
    parameter int AW = 12
) (
    input  logic [1:0]    sel,
    input  logic [AW-1:0] upc,
    input  logic [AW-1:0] areg,
    input  logic [AW-1:0] stk_top,
    input  logic [AW-1:0] direct,
    input  logic [AW-1:0] or_mask,
    input  logic          zero_n,
    output logic [AW-1:0] y
);
    import useq_pkg::*;

    src_e src;
    assign src = src_e'(sel);

    // One slice per address bit, as a stack of bit-slice parts would do.
    for (genvar b = 0; b < AW; b++) begin : g_bit
        logic picked;
        // Choose this bit from the selected source.
        always_comb begin
            unique case (src)
                SRC_UPC:    picked = upc[b];
                SRC_AREG:   picked = areg[b];
                SRC_STACK:  picked = stk_top[b];
                default:    picked = direct[b];
            endcase
        end
        // Apply the mask, then the zero override.
        assign y[b] = zero_n & (picked | or_mask[b]);
    end
endmodule

// File: rtl/useq_upc.sv
// Module: microprogram counter that reloads with the emitted address plus one.
// Assumes the incrementer carry-in is permanently one.
module useq_upc #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] y,
    output logic [AW-1:0] upc
);
    logic [AW-1:0] next_upc;

    // Increment the address; the carry-out is dropped, so it wraps.
    assign next_upc = y + AW'(1);

    // Register the incremented address every edge.
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= '0;
        else        upc <= next_upc;
    end
endmodule

// File: rtl/useq_lifo.sv
// Module: small return-address stack with saturating pointer.
// Assumes push on full overwrites the top and pop on empty is a no-op;
// an empty stack presents zero at its top output.
module useq_lifo #(
    parameter int AW    = 12,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_n,
    input  logic          push,
    input  logic [AW-1:0] din,
    output logic [AW-1:0] top
);
    localparam int PW = $clog2(DEPTH + 1);

    logic [PW-1:0] cnt;
    logic [AW-1:0] mem [DEPTH];
    logic          do_push;
    logic          do_pop;
    logic          full;
    logic [PW-1:0] wr_idx;

    // Decode the stack command.
    assign do_push = !en_n && push;
    assign do_pop  = !en_n && !push;
    assign full    = (cnt == PW'(DEPTH));
    assign wr_idx  = full ? PW'(DEPTH - 1) : cnt;

    // Track occupancy; saturate at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (do_push && !full)        cnt <= cnt + PW'(1);
        else if (do_pop && cnt != '0)     cnt <= cnt - PW'(1);
    end

    // One write port per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Store the pushed address into the addressed entry.
        always_ff @(posedge clk) begin
            if (do_push && wr_idx == PW'(i)) mem[i] <= din;
        end
    end

    // Present the current top, or zero when empty.
    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cnt == PW'(i + 1)) top = mem[i];
        end
    end
endmodule

// File: rtl/useq_addr_gen.sv
// Module: top of the next-microaddress sequencer.
// Assumes src_sel, stack controls and r_in come from the pipeline register
// and d_in from the opcode mapping table; only cs_addr reaches the store.
module useq_addr_gen #(
    parameter int AW    = 12,
    parameter int DEPTH = 4,
    parameter int CS_AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    src_sel,
    input  logic          stk_en_n,
    input  logic          stk_push,
    input  logic [AW-1:0] r_in,
    input  logic [AW-1:0] d_in,
    input  logic [AW-1:0] or_mask,
    input  logic          zero_n,
    output logic [AW-1:0] y,
    output logic [CS_AW-1:0] cs_addr
);
    logic [AW-1:0] upc;
    logic [AW-1:0] areg;
    logic [AW-1:0] stk_top;

    // Address register: enable tied active, so it follows r_in each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) areg <= '0;
        else        areg <= r_in;
    end

    useq_upc #(.AW(AW)) u_upc (
        .clk   (clk),
        .rst_n (rst_n),
        .y     (y),
        .upc   (upc)
    );

    useq_lifo #(.AW(AW), .DEPTH(DEPTH)) u_lifo (
        .clk   (clk),
        .rst_n (rst_n),
        .en_n  (stk_en_n),
        .push  (stk_push),
        .din   (upc),
        .top   (stk_top)
    );

    useq_src_mux #(.AW(AW)) u_mux (
        .sel     (src_sel),
        .upc     (upc),
        .areg    (areg),
        .stk_top (stk_top),
        .direct  (d_in),
        .or_mask (or_mask),
        .zero_n  (zero_n),
        .y       (y)
    );

    // Control-store address is the low slice of the microaddress.
    assign cs_addr = y[CS_AW-1:0];
endmodule

// File: rtl/useq_addr_gen_chk.sv
// Module: property checker bound to the sequencer top.
// Assumes a synchronous active-low reset; history registers restart with it.
module useq_addr_gen_chk #(
    parameter int AW    = 12,
    parameter int CS_AW = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       src_sel,
    input logic [AW-1:0]    r_in,
    input logic [AW-1:0]    d_in,
    input logic [AW-1:0]    or_mask,
    input logic             zero_n,
    input logic [AW-1:0]    y,
    input logic [CS_AW-1:0] cs_addr
);
    logic          hist_ok;
    logic [AW-1:0] prev_y;
    logic [AW-1:0] prev_r;

    // Keep one cycle of history, valid only after a non-reset edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_ok <= 1'b0;
            prev_y  <= '0;
            prev_r  <= '0;
        end else begin
            hist_ok <= 1'b1;
            prev_y  <= y;
            prev_r  <= r_in;
        end
    end

    p_upc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && zero_n && src_sel == 2'b00 && or_mask == '0) |-> y == AW'(prev_y + AW'(1)));

    p_rreg_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && zero_n && src_sel == 2'b01) |-> y == (prev_r | or_mask));

    p_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_n && src_sel == 2'b11) |-> y == (d_in | or_mask));

    p_mask_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        zero_n |-> (y & or_mask) == or_mask);

    p_zero_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_n |-> y == '0);

    p_cs_slice_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_addr == y[CS_AW-1:0]);
endmodule

bind useq_addr_gen useq_addr_gen_chk #(.AW(AW), .CS_AW(CS_AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_sel (src_sel),
    .r_in    (r_in),
    .d_in    (d_in),
    .or_mask (or_mask),
    .zero_n  (zero_n),
    .y       (y),
    .cs_addr (cs_addr)
);

// File: tb/test_useq_addr_gen.sv
// Bench: scoreboard for the sequencer. A driver task applies inputs at the
// falling edge, steps a reference model and queues the expected address;
// a monitor pops and compares a quarter period later.
module test_useq_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic        stk_en_n = 1'b1;
    logic        stk_push = 1'b0;
    logic [11:0] r_in = '0;
    logic [11:0] d_in = '0;
    logic [11:0] or_mask = '0;
    logic        zero_n = 1'b1;
    logic [11:0] y;
    logic [8:0]  cs_addr;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    logic [11:0] exp_q [$];
    string       tag_q [$];

    // Reference model state.
    logic [11:0] m_upc;
    logic [11:0] m_areg;
    logic [11:0] m_stk [4];
    int          m_cnt;

    always #10 clk = ~clk;

    useq_addr_gen i_useq_addr_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .stk_en_n (stk_en_n),
        .stk_push (stk_push),
        .r_in     (r_in),
        .d_in     (d_in),
        .or_mask  (or_mask),
        .zero_n   (zero_n),
        .y        (y),
        .cs_addr  (cs_addr)
    );

    task automatic model_reset();
        m_upc = '0;
        m_areg = '0;
        m_cnt = 0;
    endtask

    // Drive one cycle, queue the expected address, advance the model.
    task automatic step(input logic [1:0] sel, input logic en_n, input logic psh,
                        input logic [11:0] r, input logic [11:0] d,
                        input logic [11:0] msk, input logic zn, input string tag);
        logic [11:0] src_v;
        logic [11:0] top_v;
        logic [11:0] ey;
        @(negedge clk);
        rst_n = 1'b1; src_sel = sel; stk_en_n = en_n; stk_push = psh;
        r_in = r; d_in = d; or_mask = msk; zero_n = zn;
        top_v = (m_cnt == 0) ? 12'h000 : m_stk[m_cnt-1];
        case (sel)
            2'b00: src_v = m_upc;
            2'b01: src_v = m_areg;
            2'b10: src_v = top_v;
            default: src_v = d;
        endcase
        ey = zn ? (src_v | msk) : 12'h000;
        exp_q.push_back(ey);
        tag_q.push_back(tag);
        if (!en_n) begin
            if (psh) begin
                if (m_cnt < 4) begin m_stk[m_cnt] = m_upc; m_cnt++; end
                else m_stk[3] = m_upc;
            end else if (m_cnt > 0) m_cnt--;
        end
        m_upc = ey + 12'd1;
        m_areg = r;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; stk_en_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        model_reset();
    endtask

    // Monitor: compare each queued expectation after the outputs settle.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [11:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                compared++;
                if (y !== e) begin
                    mismatched++;
                    $display("FAIL %s: y=%h expected %h", t, y, e);
                end
                compared++;
                if (cs_addr !== e[8:0]) begin
                    mismatched++;
                    $display("FAIL R11: cs_addr=%h expected %h", cs_addr, e[8:0]);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 20);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        // R10 reset state, R1/R7 counting
        step(2'b00, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R10");
        step(2'b00, 1'b1, 1'b0, 12'h123, 12'h000, 12'h000, 1'b1, "R7");
        step(2'b00, 1'b1, 1'b0, 12'h456, 12'h000, 12'h000, 1'b1, "R1");
        // R2 register source lags r_in by one edge
        step(2'b01, 1'b1, 1'b0, 12'h789, 12'h000, 12'h000, 1'b1, "R2");
        step(2'b01, 1'b1, 1'b0, 12'h0AB, 12'h000, 12'h000, 1'b1, "R2");
        // R4 direct source, R5 mask
        step(2'b11, 1'b1, 1'b0, 12'h000, 12'h0A5, 12'h000, 1'b1, "R4");
        step(2'b11, 1'b1, 1'b0, 12'h000, 12'h100, 12'h00F, 1'b1, "R5");
        step(2'b00, 1'b1, 1'b0, 12'h000, 12'h000, 12'h800, 1'b1, "R5");
        // R6 zero force
        step(2'b11, 1'b1, 1'b0, 12'h000, 12'hFFF, 12'hFFF, 1'b0, "R6");
        step(2'b00, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R7");
        // R3 empty stack reads zero
        step(2'b10, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R3");
        // R8 call then return
        step(2'b00, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R1");
        step(2'b11, 1'b0, 1'b1, 12'h000, 12'h040, 12'h000, 1'b1, "R8");
        step(2'b00, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R7");
        step(2'b10, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R8");
        step(2'b10, 1'b0, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R8");
        step(2'b10, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R8");
        // R9 five pushes into four entries
        for (int k = 0; k < 5; k++)
            step(2'b11, 1'b0, 1'b1, 12'h000, 12'(12'h200 + k * 16), 12'h000, 1'b1, "R9");
        step(2'b10, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R9");
        // R8 disabled push changes nothing
        step(2'b11, 1'b1, 1'b1, 12'h000, 12'h3C0, 12'h000, 1'b1, "R8");
        step(2'b10, 1'b1, 1'b1, 12'h000, 12'h000, 12'h000, 1'b1, "R8");
        // R9 pop past empty
        for (int k = 0; k < 6; k++)
            step(2'b10, 1'b0, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R9");
        step(2'b10, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R3");
        step(2'b11, 1'b0, 1'b1, 12'h000, 12'h0F0, 12'h000, 1'b1, "R9");
        step(2'b10, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R9");
        // R7 wrap at the top of the address space
        step(2'b11, 1'b1, 1'b0, 12'h000, 12'hFFF, 12'h000, 1'b1, "R7");
        step(2'b00, 1'b1, 1'b0, 12'h555, 12'h000, 12'h000, 1'b1, "R7");
        // R10 mid-run reset empties the stack and clears registers
        step(2'b11, 1'b0, 1'b1, 12'h000, 12'h077, 12'h000, 1'b1, "R8");
        do_reset();
        step(2'b10, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R10");
        step(2'b01, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R10");
        step(2'b00, 1'b1, 1'b0, 12'h000, 12'h000, 12'h000, 1'b1, "R10");
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule